// File: doc/BRIEF.md
# Planar Display Memory Write Datapath with Masked-Write Extension

This block sits between a host write port and a planar display memory. It takes one host byte together with the plane latch bytes and the bytes the memory currently holds at the target address. From these it forms the byte to write into each plane and a write enable for each plane. The data is formed by a write mode (direct with per-plane set/reset, latch copy, bit expansion, or set/reset under a host-filtered mask). A raster operation (replace, AND, OR, XOR) is then applied under a bit mask. The result is presented one clock after the request, together with a one-cycle strobe.

A masked-write extension changes both the mask and the merge partner. When it is on, the mask is taken from a dedicated mask input or from the host byte itself. The merge then works against the current memory bytes instead of the latches. In write mode 0 it also provides a shortcut: when every active plane is enabled and the standard mask is not all ones, the latch bytes are copied into the masked bit positions of every plane. An eight-plane mode doubles the plane count and reverses the order in which plane-enable bits are read.

Top module: `planar_wr_path`

## Requirements
- R1: One clock after a cycle with `wr_req` high, `wr_stb` is high for exactly one cycle. After a cycle with `wr_req` low, `wr_stb` and every bit of `plane_we` are 0. After reset, `wr_stb`, `plane_we` and `plane_wdata` are all zero.
- R2: With `wide_mode` = 0, planes 0 to 3 are active, plane i is enabled by `plane_en[i]`, and planes 4 to 7 never assert their enable and carry data 0x00. With `wide_mode` = 1, all 8 planes are active and plane i is enabled by `plane_en[7-i]`.
- R3: With `write_mode` = 0, plane i uses 0xFF or 0x00, following `sr_val[i]`, when `sr_en[i]` = 1, and uses `cpu_byte` otherwise. The raster operation and the mask are then applied.
- R4: With `write_mode` = 2, plane i uses 0xFF when `cpu_byte[i]` = 1 and 0x00 otherwise. The raster operation and the mask are then applied.
- R5: With `write_mode` = 3, plane i uses 0xFF or 0x00 following `sr_val[i]`, and the mask in force is the selected mask ANDed with `cpu_byte`.
- R6: With `write_mode` = 1, each active plane receives its latch byte unchanged, and its enable follows R2.
- R7: `rop_sel` codes are 00 replace (d&m | b&~m), 01 AND ((d|~m)&b), 10 OR ((d&m)|b) and 11 XOR ((d&m)^b). Here d is the plane data, m the mask and b the merge partner.
- R8: With `mw_ctrl[0]` = 0, the mask is `std_mask`. With `mw_ctrl` = 11, the mask is `cpu_byte`. With `mw_ctrl` = 01, the mask is `mw_mask`. `mw_ctrl[1]` has no effect while `mw_ctrl[0]` = 0.
- R9: The merge partner b is the plane's latch byte (`latch_bus[8i+7:8i]`) when `mw_ctrl[0]` = 0, and the plane's current memory byte (`vram_bus[8i+7:8i]`) when `mw_ctrl[0]` = 1.
- R10: With `mw_ctrl[0]` = 1, `write_mode` = 0, every active plane enabled and `std_mask` not 0xFF, every active plane is written with (latch & m) | (vram & ~m). This takes precedence over set/reset and the raster operation.
- R11: `plane_wdata` keeps its last value through cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_req | input | 1 | Host write request for this cycle |
| write_mode | input | 2 | Write mode 0 to 3 |
| rop_sel | input | 2 | Raster operation: 00 replace, 01 AND, 10 OR, 11 XOR |
| cpu_byte | input | 8 | Host data byte (already rotated) |
| sr_val | input | 8 | Per-plane set/reset value bits |
| sr_en | input | 8 | Per-plane set/reset enable bits |
| std_mask | input | 8 | Standard bit mask |
| mw_ctrl | input | 2 | Bit 0 masked-write on, bit 1 mask from host byte |
| mw_mask | input | 8 | Masked-write mask |
| plane_en | input | 8 | Plane enable mask |
| wide_mode | input | 1 | Eight-plane mode |
| latch_bus | input | 64 | Plane latch bytes, plane i in bits 8i+7:8i |
| vram_bus | input | 64 | Current memory bytes, plane i in bits 8i+7:8i |
| wr_stb | output | 1 | Registered write strobe |
| plane_we | output | 8 | Registered per-plane write enables |
| plane_wdata | output | 64 | Registered per-plane write data |

## Verification
The latch-copy shortcut and the ordinary per-plane path compete in the same cycle whenever masked-write is on in write mode 0. To provoke this, one vector sets set/reset bits and the XOR operation together with a full plane mask and a standard mask other than 0xFF, so that both paths have an opinion about the same bytes. A second vector keeps everything the same except that the standard mask is 0xFF. The bench judges both against its own per-bit model: the first must show the latch/memory merge, the second the raster result against memory. Mask-source selection and the reversed plane order of eight-plane mode are also combined in a single vector.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [1:0] {
    ROP_PASS = 2'b00,
    ROP_AND  = 2'b01,
    ROP_OR   = 2'b10,
    ROP_XOR  = 2'b11
  } rop_e;

  typedef enum logic [1:0] {
    WM_DIRECT = 2'd0,
    WM_LATCH  = 2'd1,
    WM_SPLAT  = 2'd2,
    WM_SRMASK = 2'd3
  } wmode_e;
endpackage

// File: rtl/pwp_mask_pick.sv
module pwp_mask_pick #(
  parameter int BW = 8
) (
  input  logic          [BW-1:0] cpu_byte,
  input  logic          [BW-1:0] std_mask,
  input  logic          [1:0]    mw_ctrl,
  input  logic          [BW-1:0] mw_mask,
  input  pwp_pkg::wmode_e        mode,
  output logic          [BW-1:0] eff_mask,
  output logic                   mw_on,
  output logic                   std_full
);
  logic [BW-1:0] sel_mask;

  always_comb begin
    mw_on    = mw_ctrl[0];
    std_full = &std_mask;
    if (!mw_ctrl[0])     sel_mask = std_mask;
    else if (mw_ctrl[1]) sel_mask = cpu_byte;
    else                 sel_mask = mw_mask;
    // write mode 3 filters the selected mask with the host byte (R5)
    eff_mask = (mode == pwp_pkg::WM_SRMASK) ? (sel_mask & cpu_byte) : sel_mask;
  end
endmodule

// File: rtl/pwp_plane_lane.sv
module pwp_plane_lane #(
  parameter int BW = 8
) (
  input  logic          [BW-1:0] cpu_byte,
  input  logic                   cpu_bit,
  input  logic                   sr_bit,
  input  logic                   sr_on,
  input  logic          [BW-1:0] latch_b,
  input  logic          [BW-1:0] vram_b,
  input  logic          [BW-1:0] mask,
  input  pwp_pkg::wmode_e        mode,
  input  pwp_pkg::rop_e          rop,
  input  logic                   mw_on,
  input  logic                   shortcut,
  input  logic                   active,
  input  logic                   enabled,
  output logic                   we,
  output logic          [BW-1:0] data
);
  logic [BW-1:0] base;
  logic [BW-1:0] src;
  logic [BW-1:0] merged;

  always_comb begin
    base = mw_on ? vram_b : latch_b;
    unique case (mode)
      pwp_pkg::WM_DIRECT: src = sr_on ? {BW{sr_bit}} : cpu_byte;
      pwp_pkg::WM_SPLAT:  src = {BW{cpu_bit}};
      pwp_pkg::WM_SRMASK: src = {BW{sr_bit}};
      default:            src = latch_b;
    endcase
    unique case (rop)
      pwp_pkg::ROP_AND: merged = (src | ~mask) & base;
      pwp_pkg::ROP_OR:  merged = (src & mask) | base;
      pwp_pkg::ROP_XOR: merged = (src & mask) ^ base;
      default:          merged = (src & mask) | (base & ~mask);
    endcase
    if (!active) begin
      we   = 1'b0;
      data = '0;
    end else if (shortcut) begin
      we   = 1'b1;
      data = (latch_b & mask) | (vram_b & ~mask);
    end else if (mode == pwp_pkg::WM_LATCH) begin
      we   = enabled;
      data = latch_b;
    end else begin
      we   = enabled;
      data = merged;
    end
  end
endmodule

// File: rtl/planar_wr_path.sv
module planar_wr_path #(
  parameter int PLANES = 8,
  parameter int BW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [1:0]           write_mode,
  input  logic [1:0]           rop_sel,
  input  logic [BW-1:0]        cpu_byte,
  input  logic [PLANES-1:0]    sr_val,
  input  logic [PLANES-1:0]    sr_en,
  input  logic [BW-1:0]        std_mask,
  input  logic [1:0]           mw_ctrl,
  input  logic [BW-1:0]        mw_mask,
  input  logic [PLANES-1:0]    plane_en,
  input  logic                 wide_mode,
  input  logic [PLANES*BW-1:0] latch_bus,
  input  logic [PLANES*BW-1:0] vram_bus,
  output logic                 wr_stb,
  output logic [PLANES-1:0]    plane_we,
  output logic [PLANES*BW-1:0] plane_wdata
);
  localparam int NARROW = PLANES / 2;

  logic [1:0]           rst_sync;
  logic                 rst_ok;
  logic [BW-1:0]        eff_mask;
  logic                 mw_on;
  logic                 std_full;
  logic [PLANES-1:0]    lane_act;
  logic [PLANES-1:0]    lane_pen;
  logic                 all_on;
  logic                 shortcut;
  logic [PLANES-1:0]    lane_we;
  logic [PLANES*BW-1:0] lane_wd;
  logic                 stb_d;
  logic [PLANES-1:0]    we_d;
  logic [PLANES*BW-1:0] wd_d;
  pwp_pkg::wmode_e      mode;
  pwp_pkg::rop_e        rop;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  assign mode = pwp_pkg::wmode_e'(write_mode);
  assign rop  = pwp_pkg::rop_e'(rop_sel);

  pwp_mask_pick #(.BW(BW)) u_mask (
    .cpu_byte (cpu_byte),
    .std_mask (std_mask),
    .mw_ctrl  (mw_ctrl),
    .mw_mask  (mw_mask),
    .mode     (mode),
    .eff_mask (eff_mask),
    .mw_on    (mw_on),
    .std_full (std_full)
  );

  for (genvar i = 0; i < PLANES; i++) begin : g_lane
    // eight-plane mode reads enable bits in reverse order (R2)
    assign lane_act[i] = wide_mode || (i < NARROW);
    assign lane_pen[i] = wide_mode ? plane_en[PLANES-1-i] : plane_en[i];

    pwp_plane_lane #(.BW(BW)) u_lane (
      .cpu_byte (cpu_byte),
      .cpu_bit  (cpu_byte[i % BW]),
      .sr_bit   (sr_val[i]),
      .sr_on    (sr_en[i]),
      .latch_b  (latch_bus[i*BW +: BW]),
      .vram_b   (vram_bus[i*BW +: BW]),
      .mask     (eff_mask),
      .mode     (mode),
      .rop      (rop),
      .mw_on    (mw_on),
      .shortcut (shortcut),
      .active   (lane_act[i]),
      .enabled  (lane_pen[i]),
      .we       (lane_we[i]),
      .data     (lane_wd[i*BW +: BW])
    );
  end

  always_comb begin
    all_on   = &(lane_pen | ~lane_act);
    shortcut = mw_on && (mode == pwp_pkg::WM_DIRECT) && all_on && !std_full;
    stb_d    = wr_req;
    we_d     = wr_req ? lane_we : '0;
    wd_d     = wr_req ? lane_wd : plane_wdata;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      wr_stb      <= 1'b0;
      plane_we    <= '0;
      plane_wdata <= '0;
    end else begin
      wr_stb      <= stb_d;
      plane_we    <= we_d;
      plane_wdata <= wd_d;
    end
  end
endmodule

// File: rtl/planar_wr_path_chk.sv
module planar_wr_path_chk #(
  parameter int PLANES = 8,
  parameter int BW     = 8
) (
  input logic                 clk,
  input logic                 rst_ok,
  input logic                 wr_req,
  input logic [1:0]           write_mode,
  input logic                 wide_mode,
  input logic [1:0]           mw_ctrl,
  input logic [BW-1:0]        mw_mask,
  input logic [PLANES*BW-1:0] latch_bus,
  input logic [PLANES*BW-1:0] vram_bus,
  input logic                 wr_stb,
  input logic [PLANES-1:0]    plane_we,
  input logic [PLANES*BW-1:0] plane_wdata
);
  p_stb_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_req |=> wr_stb);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_req |=> (!wr_stb && plane_we == '0));

  p_upper_idle_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_req && !wide_mode) |=> (plane_we[PLANES-1:PLANES/2] == '0));

  p_latch_copy_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_req && write_mode == 2'd1) |=> (plane_wdata[BW-1:0] == $past(latch_bus[BW-1:0])));

  p_zero_mask_keeps_vram_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_req && mw_ctrl == 2'b01 && mw_mask == '0 && write_mode == 2'd2)
      |=> (plane_wdata[BW-1:0] == $past(vram_bus[BW-1:0])));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_req |=> $stable(plane_wdata));
endmodule

bind planar_wr_path planar_wr_path_chk #(.PLANES(PLANES), .BW(BW)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_ok),
  .wr_req      (wr_req),
  .write_mode  (write_mode),
  .wide_mode   (wide_mode),
  .mw_ctrl     (mw_ctrl),
  .mw_mask     (mw_mask),
  .latch_bus   (latch_bus),
  .vram_bus    (vram_bus),
  .wr_stb      (wr_stb),
  .plane_we    (plane_we),
  .plane_wdata (plane_wdata)
);

// File: tb/sim_planar_wr_path.sv
module sim_planar_wr_path;
  localparam logic [63:0] LAT = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] VRM = 64'h0F1E_2D3C_4B5A_6978;

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] mode;
    logic [1:0] rop;
    logic [7:0] cpu;
    logic [7:0] srv;
    logic [7:0] sre;
    logic [7:0] stdm;
    logic [1:0] mwc;
    logic [7:0] mwm;
    logic [7:0] pen;
    logic       wide;
  } vec_t;

  localparam int NV = 17;
  // req, mode, rop, cpu, srv, sre, std, mwc, mwm, pen, wide
  localparam vec_t VECS [NV] = '{
    '{4'd3,  2'd0, 2'd0, 8'h5A, 8'h00, 8'h00, 8'hFF, 2'd0, 8'h00, 8'h0F, 1'b0}, // R3 plain
    '{4'd3,  2'd0, 2'd0, 8'hC3, 8'h01, 8'h05, 8'hFF, 2'd0, 8'h00, 8'h0F, 1'b0}, // R3 set/reset
    '{4'd7,  2'd0, 2'd1, 8'h96, 8'h00, 8'h00, 8'h3C, 2'd0, 8'h00, 8'h0B, 1'b0}, // R7 AND
    '{4'd7,  2'd0, 2'd2, 8'h96, 8'h00, 8'h00, 8'hA5, 2'd0, 8'h00, 8'h0F, 1'b0}, // R7 OR
    '{4'd7,  2'd0, 2'd3, 8'h69, 8'h00, 8'h00, 8'h5A, 2'd0, 8'h00, 8'h0E, 1'b0}, // R7 XOR
    '{4'd4,  2'd2, 2'd0, 8'h06, 8'h00, 8'h00, 8'hF0, 2'd0, 8'h00, 8'h0F, 1'b0}, // R4
    '{4'd4,  2'd2, 2'd3, 8'hA5, 8'h00, 8'h00, 8'hFF, 2'd0, 8'h00, 8'h81, 1'b1}, // R4 wide
    '{4'd5,  2'd3, 2'd0, 8'h3C, 8'h0A, 8'h00, 8'h0F, 2'd0, 8'h00, 8'h0F, 1'b0}, // R5
    '{4'd6,  2'd1, 2'd2, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0, 8'h00, 8'h06, 1'b0}, // R6
    '{4'd9,  2'd2, 2'd0, 8'h05, 8'h00, 8'h00, 8'hFF, 2'd1, 8'h0F, 8'h03, 1'b0}, // R9 reg mask
    '{4'd8,  2'd0, 2'd0, 8'h3C, 8'h00, 8'h00, 8'hFF, 2'd3, 8'h00, 8'h05, 1'b0}, // R8 host mask
    '{4'd10, 2'd0, 2'd3, 8'hAA, 8'h01, 8'h03, 8'h7E, 2'd1, 8'hC3, 8'h0F, 1'b0}, // R10 shortcut wins
    '{4'd9,  2'd0, 2'd3, 8'hAA, 8'h01, 8'h03, 8'hFF, 2'd1, 8'hC3, 8'h0F, 1'b0}, // R9 no shortcut
    '{4'd5,  2'd3, 2'd1, 8'h3C, 8'h05, 8'h00, 8'h00, 2'd1, 8'hF0, 8'h0F, 1'b0}, // R5 masked
    '{4'd8,  2'd2, 2'd0, 8'h09, 8'h00, 8'h00, 8'h0F, 2'd2, 8'h00, 8'h0F, 1'b0}, // R8 bit1 alone
    '{4'd10, 2'd0, 2'd0, 8'h55, 8'h00, 8'h00, 8'h12, 2'd1, 8'h0F, 8'hFF, 1'b1}, // R10 wide
    '{4'd2,  2'd0, 2'd2, 8'h81, 8'h00, 8'h00, 8'hFF, 2'd0, 8'h00, 8'h0F, 1'b1}  // R2 reversed
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic [1:0]  write_mode = '0, rop_sel = '0, mw_ctrl = '0;
  logic [7:0]  cpu_byte = '0, sr_val = '0, sr_en = '0, std_mask = '0, mw_mask = '0, plane_en = '0;
  logic        wide_mode = 1'b0;
  logic [63:0] latch_bus = LAT, vram_bus = VRM;
  logic        wr_stb;
  logic [7:0]  plane_we;
  logic [63:0] plane_wdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  planar_wr_path u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .write_mode(write_mode), .rop_sel(rop_sel),
    .cpu_byte(cpu_byte), .sr_val(sr_val), .sr_en(sr_en), .std_mask(std_mask),
    .mw_ctrl(mw_ctrl), .mw_mask(mw_mask), .plane_en(plane_en), .wide_mode(wide_mode),
    .latch_bus(latch_bus), .vram_bus(vram_bus), .wr_stb(wr_stb), .plane_we(plane_we),
    .plane_wdata(plane_wdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent per-bit model of the requirements
  function automatic void ref_model(input vec_t v, output logic [7:0] we, output logic [63:0] wd);
    logic [7:0] m, d, lat, vr, bs;
    logic       mw, full, en;
    int         n;
    mw = v.mwc[0];
    m  = !mw ? v.stdm : (v.mwc[1] ? v.cpu : v.mwm);
    if (v.mode == 2'd3) m = m & v.cpu;
    n = v.wide ? 8 : 4;
    full = 1'b1;
    for (int p = 0; p < n; p++)
      if (!(v.wide ? v.pen[7-p] : v.pen[p])) full = 1'b0;
    we = '0;
    wd = '0;
    for (int p = 0; p < n; p++) begin
      lat = LAT[p*8 +: 8];
      vr  = VRM[p*8 +: 8];
      bs  = mw ? vr : lat;
      en  = v.wide ? v.pen[7-p] : v.pen[p];
      if (mw && v.mode == 2'd0 && full && v.stdm != 8'hFF) begin
        we[p] = 1'b1;
        for (int b = 0; b < 8; b++) wd[p*8+b] = m[b] ? lat[b] : vr[b];
      end else begin
        we[p] = en;
        case (v.mode)
          2'd0: d = v.sre[p] ? {8{v.srv[p]}} : v.cpu;
          2'd2: d = {8{v.cpu[p]}};
          default: d = {8{v.srv[p]}};
        endcase
        for (int b = 0; b < 8; b++) begin
          if (v.mode == 2'd1) wd[p*8+b] = lat[b];
          else if (!m[b])     wd[p*8+b] = bs[b];
          else case (v.rop)
            2'd0: wd[p*8+b] = d[b];
            2'd1: wd[p*8+b] = d[b] & bs[b];
            2'd2: wd[p*8+b] = d[b] | bs[b];
            default: wd[p*8+b] = d[b] ^ bs[b];
          endcase
        end
      end
    end
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  ewe;
    logic [63:0] ewd, held;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check("R1 reset stb", {63'd0, wr_stb}, 64'd0);
    check("R1 reset we", {56'd0, plane_we}, 64'd0);
    check("R1 reset data", plane_wdata, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      write_mode = VECS[k].mode;  rop_sel  = VECS[k].rop;   cpu_byte = VECS[k].cpu;
      sr_val     = VECS[k].srv;   sr_en    = VECS[k].sre;   std_mask = VECS[k].stdm;
      mw_ctrl    = VECS[k].mwc;   mw_mask  = VECS[k].mwm;   plane_en = VECS[k].pen;
      wide_mode  = VECS[k].wide;  wr_req   = 1'b1;
      @(negedge clk);
      wr_req = 1'b0;
      ref_model(VECS[k], ewe, ewd);
      check($sformatf("R%0d vec%0d stb", VECS[k].req, k), {63'd0, wr_stb}, 64'd1);
      check($sformatf("R%0d vec%0d we", VECS[k].req, k), {56'd0, plane_we}, {56'd0, ewe});
      check($sformatf("R%0d vec%0d data", VECS[k].req, k), plane_wdata, ewd);
    end

    // R1: strobe lasts one cycle; R11: data held while idle
    held = plane_wdata;
    @(negedge clk);
    check("R1 stb drops", {63'd0, wr_stb}, 64'd0);
    check("R1 we idle", {56'd0, plane_we}, 64'd0);
    cpu_byte = 8'h00;
    write_mode = 2'd2;
    @(negedge clk);
    check("R11 data held", plane_wdata, held);

    // R2: narrow mode never enables upper planes, even with all enable bits set
    write_mode = 2'd0; rop_sel = 2'd0; cpu_byte = 8'h3C; sr_en = 8'h00;
    std_mask = 8'hFF; mw_ctrl = 2'd0; plane_en = 8'hFF; wide_mode = 1'b0; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    check("R2 narrow we", {56'd0, plane_we}, 64'h0F);
    check("R2 narrow data", plane_wdata, 64'h0000_0000_3C3C_3C3C);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule